// File: doc/BRIEF.md
# Waveform Sampler Capture and Readout Sequencer

This block runs the control sequence for a switched-capacitor waveform sampler chip. After reset it waits a settle time and then raises the sampler enable, which stays high from then on. When a capture request arrives it programs three serial registers of the sampler over a shared serial clock and data pair. The first gets the pattern 8'h55, the second gets 8'hFF, and the read shift register gets 1024 zero bits.

Once programmed, it arms sampling by holding the write output high with the address bus at 4'b1011. When the trigger arrives it drops the write output and waits a short freeze delay. It then switches the address to 4'b1101, waits a long settle, pulses the read-shift-register load strobe and waits a short gap. After that it reads the 10-bit stop position from the serial output, most significant bit first. Finally it moves the address to 4'b0000 and waits the analog clock-out delay. At that point it raises a one-cycle done pulse and presents the latched stop position.

Every delay is given in nanoseconds and turned into system clock cycles, rounding up, from a clock frequency parameter. The serial clock high and low phases each last a parameter number of system cycles.

Top module: `wfs_capture_seq`

## Requirements
- R1: While reset is held, every output is low and the address is 4'b0000. After reset is released, the enable output rises on the ceil(SETTLE_NS·CLK_HZ/1e9)-th clock edge (50 cycles by default) and never falls afterwards.
- R2: A capture request is acted on only while the block is idle. A request held during readout has no effect: after done, the write, serial clock and address outputs stay low and 4'b0000.
- R3: Before the write output rises, the serial port delivers three patterns, one per address, each on rising serial clock edges and most significant bit first. Address 4'b1111 receives exactly 8 bits forming 8'h55. Address 4'b1110 receives exactly 8 bits forming 8'hFF. Address 4'b1100 receives exactly 1024 bits, all zero.
- R4: While armed, the write output is high and the address is 4'b1011. A trigger seen before arming has no effect on this.
- R5: The write output falls on the first clock edge at which it is high and the trigger is high. The address then stays at 4'b1011 for ceil(40 ns) cycles, which is 2 cycles at 50 MHz.
- R6: The address 4'b1101 is held for ceil(150 us) cycles (7500) before the load strobe rises. The strobe stays high for ceil(30 ns) cycles (2). During the strobe, write and serial clock are low.
- R7: The stop position is built from 10 serial output samples, most significant bit first. The first sample is taken before any serial clock edge and at least ceil(30 ns) cycles after the strobe falls, and exactly 9 rising serial clock edges occur during readout. The stop position output changes only in the done cycle.
- R8: After readout the address is 4'b0000 for ceil(350 ns) cycles (18) before done. Done lasts exactly one cycle, and during it the address is 4'b0000 and the stop position holds the value read.
- R9: Serial data changes only while the serial clock is low. The serial clock is low whenever write is high or the strobe is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cap_req | input | 1 | Capture request, level, sampled while idle |
| trigger | input | 1 | External trigger, sampled while armed |
| sr_dout | input | 1 | Serial output of the sampler |
| smp_enable | output | 1 | Sampler enable |
| smp_write | output | 1 | Sampling active (write) |
| mux_addr | output | 4 | Sampler multiplexer address |
| rsr_load | output | 1 | Read shift register load strobe |
| sr_clk | output | 1 | Serial clock |
| sr_din | output | 1 | Serial data to the sampler |
| stop_pos | output | 10 | Latched stop position |
| cap_done | output | 1 | One-cycle hand-off pulse |

## Verification
The trigger and the end of programming can land in the same cycle. The bench provokes this by raising the trigger during the read-register fill, so that the trigger is already high on the first armed cycle. The write output must then be high for exactly one sample, and the rest of the timing must be unchanged. A second overlap is a capture request that arrives while readout is running. The bench holds the request through readout and releases it before the block goes idle. It then judges at the ports that no new programming starts after done.

// File: rtl/wfs_seq_pkg.sv
`timescale 1ns/1ps
package wfs_seq_pkg;

    typedef logic [3:0] addr_t;

    // multiplexer address codes; the sampler decodes these
    localparam addr_t A_IDLE = 4'b0000;
    localparam addr_t A_ARM  = 4'b1011;
    localparam addr_t A_READ = 4'b1101;
    localparam addr_t A_WSR  = 4'b1111;
    localparam addr_t A_WCR  = 4'b1110;
    localparam addr_t A_RSR  = 4'b1100;

    typedef enum logic [3:0] {
        ST_SETTLE, ST_IDLE, ST_CFG_WSR, ST_CFG_WCR, ST_CFG_RSR,
        ST_ARMED, ST_FREEZE, ST_ADDR, ST_LOAD, ST_GAP, ST_READ,
        ST_HANDOFF, ST_DONE
    } seq_st_e;

    typedef enum logic [1:0] {SH_IDLE, SH_LOW, SH_HIGH} sh_st_e;

    // nanoseconds to clock cycles, rounded up, at least one
    function automatic int ns_to_cycles(longint ns, longint hz);
        longint c;
        c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
        return (c < 1) ? 1 : int'(c);
    endfunction

endpackage

// File: rtl/wfs_delay_timer.sv
`timescale 1ns/1ps
module wfs_delay_timer #(
    parameter int W       = 13,
    parameter int RST_CNT = 49
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] cycles,
    output logic         expired
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         run;
    } tmr_t;

    tmr_t q, d;

    assign expired = q.run && (q.cnt == '0);

    always_comb begin
        d = q;
        if (load) begin
            d.cnt = cycles - W'(1);
            d.run = 1'b1;
        end else if (expired) begin
            d.run = 1'b0;
        end else if (q.run) begin
            d.cnt = q.cnt - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt <= W'(RST_CNT);
            q.run <= 1'b1;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/wfs_serial_engine.sv
`timescale 1ns/1ps
module wfs_serial_engine
    import wfs_seq_pkg::*;
#(
    parameter int IDX_W     = 10,
    parameter int SR_HALF   = 1,
    parameter int STOP_BITS = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 mode_rd,
    input  logic [IDX_W-1:0]     last,
    input  logic                 tx_bit,
    input  logic                 sr_dout,
    output logic [IDX_W-1:0]     idx,
    output logic                 sr_clk,
    output logic                 sr_din,
    output logic                 done,
    output logic [STOP_BITS-1:0] rx_word
);
    localparam int HW = $clog2(SR_HALF + 1);
    localparam logic [HW-1:0] HC_END = HW'(SR_HALF - 1);

    typedef struct packed {
        sh_st_e               st;
        logic [HW-1:0]        hc;
        logic [IDX_W-1:0]     idx;
        logic [IDX_W-1:0]     last;
        logic                 rd;
        logic                 sclk;
        logic [STOP_BITS-1:0] rx;
    } sh_t;

    sh_t q, d;
    logic fin;

    always_comb begin
        d   = q;
        fin = 1'b0;
        case (q.st)
            SH_IDLE: begin
                if (start) begin
                    d.st   = SH_LOW;
                    d.hc   = '0;
                    d.idx  = '0;
                    d.last = last;
                    d.rd   = mode_rd;
                    d.sclk = 1'b0;
                end
            end
            SH_LOW: begin
                if (q.hc == HC_END) begin
                    d.hc = '0;
                    if (q.rd) begin
                        d.rx = {q.rx[STOP_BITS-2:0], sr_dout};
                    end
                    if (q.rd && (q.idx == q.last)) begin
                        d.st = SH_IDLE;
                        fin  = 1'b1;
                    end else begin
                        d.st   = SH_HIGH;
                        d.sclk = 1'b1;
                    end
                end else begin
                    d.hc = q.hc + HW'(1);
                end
            end
            SH_HIGH: begin
                if (q.hc == HC_END) begin
                    d.hc   = '0;
                    d.sclk = 1'b0;
                    if (!q.rd && (q.idx == q.last)) begin
                        d.st = SH_IDLE;
                        fin  = 1'b1;
                    end else begin
                        d.st  = SH_LOW;
                        d.idx = q.idx + IDX_W'(1);
                    end
                end else begin
                    d.hc = q.hc + HW'(1);
                end
            end
            default: d.st = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= SH_IDLE;
            q.hc   <= '0;
            q.idx  <= '0;
            q.last <= '0;
            q.rd   <= 1'b0;
            q.sclk <= 1'b0;
            q.rx   <= '0;
        end else begin
            q <= d;
        end
    end

    assign idx     = q.idx;
    assign sr_clk  = q.sclk;
    assign sr_din  = (q.st != SH_IDLE) && !q.rd && tx_bit;
    assign done    = fin;
    assign rx_word = q.rx;
endmodule

// File: rtl/wfs_capture_seq.sv
`timescale 1ns/1ps
module wfs_capture_seq
    import wfs_seq_pkg::*;
#(
    parameter longint CLK_HZ     = 50_000_000,
    parameter longint SETTLE_NS  = 1000,
    parameter longint FREEZE_NS  = 40,
    parameter longint HOLD_NS    = 150_000,
    parameter longint LOAD_NS    = 30,
    parameter longint GAP_NS     = 30,
    parameter longint HANDOFF_NS = 350,
    parameter int     SR_HALF    = 1,
    parameter int     CFG_BITS   = 8,
    parameter logic [CFG_BITS-1:0] PAT_WSR = 8'h55,
    parameter logic [CFG_BITS-1:0] PAT_WCR = 8'hFF,
    parameter int     RSR_BITS   = 1024,
    parameter int     STOP_BITS  = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cap_req,
    input  logic                 trigger,
    input  logic                 sr_dout,
    output logic                 smp_enable,
    output logic                 smp_write,
    output logic [3:0]           mux_addr,
    output logic                 rsr_load,
    output logic                 sr_clk,
    output logic                 sr_din,
    output logic [STOP_BITS-1:0] stop_pos,
    output logic                 cap_done
);
    localparam int T_SETTLE = ns_to_cycles(SETTLE_NS, CLK_HZ);
    localparam int T_FRZ    = ns_to_cycles(FREEZE_NS, CLK_HZ);
    localparam int T_HOLD   = ns_to_cycles(HOLD_NS, CLK_HZ);
    localparam int T_LOAD   = ns_to_cycles(LOAD_NS, CLK_HZ);
    localparam int T_GAP    = ns_to_cycles(GAP_NS, CLK_HZ);
    localparam int T_HO     = ns_to_cycles(HANDOFF_NS, CLK_HZ);
    localparam int T_M1     = (T_SETTLE > T_HOLD) ? T_SETTLE : T_HOLD;
    localparam int T_M2     = (T_FRZ > T_HO) ? T_FRZ : T_HO;
    localparam int T_M3     = (T_LOAD > T_GAP) ? T_LOAD : T_GAP;
    localparam int T_M4     = (T_M1 > T_M2) ? T_M1 : T_M2;
    localparam int T_MAX    = (T_M4 > T_M3) ? T_M4 : T_M3;
    localparam int TMR_W    = $clog2(T_MAX + 1);
    localparam int IDX_W    = $clog2(RSR_BITS);
    localparam logic [CFG_BITS-1:0] ONE = CFG_BITS'(1);

    typedef struct packed {
        seq_st_e              st;
        logic                 start;
        logic [STOP_BITS-1:0] stop;
    } seq_t;

    seq_t q, d;

    logic             tmr_load, tmr_exp;
    logic [TMR_W-1:0] tmr_val;
    logic             sh_done, sh_tx, sh_rd;
    logic [IDX_W-1:0] sh_idx, sh_last, cfg_rev;
    logic [STOP_BITS-1:0] sh_rx;

    wfs_delay_timer #(
        .W       (TMR_W),
        .RST_CNT (T_SETTLE - 1)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .cycles  (tmr_val),
        .expired (tmr_exp)
    );

    wfs_serial_engine #(
        .IDX_W     (IDX_W),
        .SR_HALF   (SR_HALF),
        .STOP_BITS (STOP_BITS)
    ) u_serial (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (q.start),
        .mode_rd (sh_rd),
        .last    (sh_last),
        .tx_bit  (sh_tx),
        .sr_dout (sr_dout),
        .idx     (sh_idx),
        .sr_clk  (sr_clk),
        .sr_din  (sr_din),
        .done    (sh_done),
        .rx_word (sh_rx)
    );

    // serial job description for the current phase
    always_comb begin
        cfg_rev = IDX_W'(CFG_BITS - 1) - sh_idx;
        sh_rd   = (q.st == ST_READ);
        sh_tx   = 1'b0;
        sh_last = IDX_W'(CFG_BITS - 1);
        case (q.st)
            ST_CFG_WSR: sh_tx = |(PAT_WSR & (ONE << cfg_rev));
            ST_CFG_WCR: sh_tx = |(PAT_WCR & (ONE << cfg_rev));
            ST_CFG_RSR: sh_last = IDX_W'(RSR_BITS - 1);
            ST_READ:    sh_last = IDX_W'(STOP_BITS - 1);
            default:    sh_tx = 1'b0;
        endcase
    end

    // sequence control
    always_comb begin
        d        = q;
        d.start  = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = TMR_W'(1);
        case (q.st)
            ST_SETTLE: if (tmr_exp) d.st = ST_IDLE;
            ST_IDLE: begin
                if (cap_req) begin
                    d.st    = ST_CFG_WSR;
                    d.start = 1'b1;
                end
            end
            ST_CFG_WSR: begin
                if (sh_done) begin
                    d.st    = ST_CFG_WCR;
                    d.start = 1'b1;
                end
            end
            ST_CFG_WCR: begin
                if (sh_done) begin
                    d.st    = ST_CFG_RSR;
                    d.start = 1'b1;
                end
            end
            ST_CFG_RSR: if (sh_done) d.st = ST_ARMED;
            ST_ARMED: begin
                if (trigger) begin
                    d.st     = ST_FREEZE;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(T_FRZ);
                end
            end
            ST_FREEZE: begin
                if (tmr_exp) begin
                    d.st     = ST_ADDR;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(T_HOLD);
                end
            end
            ST_ADDR: begin
                if (tmr_exp) begin
                    d.st     = ST_LOAD;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(T_LOAD);
                end
            end
            ST_LOAD: begin
                if (tmr_exp) begin
                    d.st     = ST_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(T_GAP);
                end
            end
            ST_GAP: begin
                if (tmr_exp) begin
                    d.st    = ST_READ;
                    d.start = 1'b1;
                end
            end
            ST_READ: begin
                if (sh_done) begin
                    d.st     = ST_HANDOFF;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(T_HO);
                end
            end
            ST_HANDOFF: begin
                if (tmr_exp) begin
                    d.st   = ST_DONE;
                    d.stop = sh_rx;
                end
            end
            ST_DONE: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= ST_SETTLE;
            q.start <= 1'b0;
            q.stop  <= '0;
        end else begin
            q <= d;
        end
    end

    // output decode
    always_comb begin
        smp_enable = (q.st != ST_SETTLE) && rst_n;
        smp_write  = (q.st == ST_ARMED);
        rsr_load   = (q.st == ST_LOAD);
        cap_done   = (q.st == ST_DONE);
        case (q.st)
            ST_CFG_WSR:                   mux_addr = A_WSR;
            ST_CFG_WCR:                   mux_addr = A_WCR;
            ST_CFG_RSR:                   mux_addr = A_RSR;
            ST_ARMED, ST_FREEZE:          mux_addr = A_ARM;
            ST_ADDR, ST_LOAD, ST_GAP,
            ST_READ:                      mux_addr = A_READ;
            default:                      mux_addr = A_IDLE;
        endcase
    end

    assign stop_pos = q.stop;
endmodule

// File: rtl/wfs_capture_seq_chk.sv
`timescale 1ns/1ps
module wfs_capture_seq_chk
    import wfs_seq_pkg::*;
#(
    parameter int STOP_BITS = 10
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 trigger,
    input logic                 smp_enable,
    input logic                 smp_write,
    input logic [3:0]           mux_addr,
    input logic                 rsr_load,
    input logic                 sr_clk,
    input logic                 sr_din,
    input logic [STOP_BITS-1:0] stop_pos,
    input logic                 cap_done
);
    assert_enable_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        smp_enable |=> smp_enable);

    assert_arm_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        smp_write |-> (mux_addr == A_ARM));

    assert_write_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_write && trigger) |=> !smp_write);

    assert_load_ctx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsr_load |-> (mux_addr == A_READ && !smp_write && !sr_clk));

    assert_stop_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stop_pos) |-> cap_done);

    assert_done_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_done |-> (mux_addr == A_IDLE));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_done |=> !cap_done);

    assert_din_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sr_din) |-> !sr_clk);

    assert_sclk_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_write || rsr_load) |-> !sr_clk);
endmodule

bind wfs_capture_seq wfs_capture_seq_chk #(.STOP_BITS(STOP_BITS)) u_chk (.*);

// File: tb/wfs_capture_seq_bench.sv
`timescale 1ns/1ps
module wfs_capture_seq_bench;
    import wfs_seq_pkg::*;

    logic clk = 1'b0, rst_n = 1'b0, cap_req = 1'b0, trigger = 1'b0;
    logic sr_dout;
    logic smp_enable, smp_write, rsr_load, sr_clk, sr_din, cap_done;
    logic [3:0] mux_addr;
    logic [9:0] stop_pos;

    always #10 clk = ~clk;

    wfs_capture_seq u_wfs_capture_seq (
        .clk(clk), .rst_n(rst_n), .cap_req(cap_req), .trigger(trigger),
        .sr_dout(sr_dout), .smp_enable(smp_enable), .smp_write(smp_write),
        .mux_addr(mux_addr), .rsr_load(rsr_load), .sr_clk(sr_clk),
        .sr_din(sr_din), .stop_pos(stop_pos), .cap_done(cap_done)
    );

    int n_tests = 0, n_fail = 0;

    function automatic int ceil_cyc(longint ns);
        longint c;
        c = (ns * 50_000_000 + 999_999_999) / 1_000_000_000;
        return (c < 1) ? 1 : int'(c);
    endfunction

    localparam int E_SETTLE = ceil_cyc(1000);
    localparam int E_FRZ    = ceil_cyc(40);
    localparam int E_HOLD   = ceil_cyc(150_000);
    localparam int E_LOAD   = ceil_cyc(30);
    localparam int E_HO     = ceil_cyc(350);

    // sampler model: serial registers and stop-position output
    logic [7:0] wsr_win = '0, wcr_win = '0;
    logic [9:0] rd_reg = '0, stop_val = '0;
    int wsr_n = 0, wcr_n = 0, rsr_n = 0, rsr_ones = 0, rd_edges = 0;

    always @(posedge sr_clk or posedge rsr_load) begin
        if (rsr_load) begin
            rd_reg <= stop_val;
        end else begin
            case (mux_addr)
                A_READ: begin rd_reg <= rd_reg << 1; rd_edges <= rd_edges + 1; end
                A_WSR:  begin wsr_win <= {wsr_win[6:0], sr_din}; wsr_n <= wsr_n + 1; end
                A_WCR:  begin wcr_win <= {wcr_win[6:0], sr_din}; wcr_n <= wcr_n + 1; end
                A_RSR:  begin rsr_n <= rsr_n + 1; rsr_ones <= rsr_ones + int'(sr_din); end
                default: ;
            endcase
        end
    end
    assign sr_dout = rd_reg[9];

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic run_capture(input logic [9:0] sv, input int arm_wait,
                               input bit early_trig, input bit glitch);
        int w0, c0, r0, o0, e0, cnt, bad;
        logic [9:0] prev_stop;
        stop_val  = sv;
        prev_stop = stop_pos;
        w0 = wsr_n; c0 = wcr_n; r0 = rsr_n; o0 = rsr_ones; e0 = rd_edges;
        cap_req = 1'b1;
        repeat ($urandom_range(1, 3)) tick;
        cap_req = 1'b0;
        if (glitch) begin
            repeat (5) tick;
            trigger = 1'b1;
            repeat (3) tick;
            trigger = 1'b0;
        end
        if (early_trig) begin
            while (rsr_n - r0 < 1000) tick;
            trigger = 1'b1;
        end
        while (!smp_write) tick;
        chk("R3", "wsr pattern", wsr_win, 8'h55);
        chk("R3", "wcr pattern", wcr_win, 8'hFF);
        chk("R3", "wsr bits", wsr_n - w0, 8);
        chk("R3", "wcr bits", wcr_n - c0, 8);
        chk("R3", "rsr bits", rsr_n - r0, 1024);
        chk("R3", "rsr ones", rsr_ones - o0, 0);
        chk("R4", "armed addr", mux_addr, A_ARM);
        if (!early_trig) begin
            cnt = 0;
            repeat (arm_wait) begin
                tick;
                if (smp_write && mux_addr == A_ARM) cnt++;
            end
            chk("R4", "armed hold samples", cnt, arm_wait);
            trigger = 1'b1;
        end
        tick;
        chk("R5", "write after trigger", smp_write, 0);
        trigger = 1'b0;
        cnt = 0;
        while (mux_addr == A_ARM && !smp_write) begin cnt++; tick; end
        chk("R5", "freeze cycles", cnt, E_FRZ);
        cnt = 0;
        while (mux_addr == A_READ && !rsr_load) begin cnt++; tick; end
        chk("R6", "hold before load", cnt, E_HOLD);
        cnt = 0; bad = 0;
        while (rsr_load) begin
            if (mux_addr != A_READ || smp_write || sr_clk) bad++;
            cnt++;
            tick;
        end
        chk("R6", "load width", cnt, E_LOAD);
        chk("R6", "load context errors", bad, 0);
        cap_req = 1'b1;
        bad = 0;
        while (mux_addr == A_READ) begin
            if (stop_pos !== prev_stop) bad++;
            tick;
        end
        cap_req = 1'b0;
        chk("R7", "read clock edges", rd_edges - e0, 9);
        cnt = 0;
        while (!cap_done) begin
            if (stop_pos !== prev_stop) bad++;
            if (mux_addr != A_IDLE) bad++;
            cnt++;
            tick;
        end
        chk("R8", "handoff cycles", cnt, E_HO);
        chk("R7", "stop unchanged before done", bad, 0);
        chk("R7", "stop position", stop_pos, sv);
        chk("R8", "done addr", mux_addr, A_IDLE);
        tick;
        chk("R8", "done width", cap_done, 0);
        cnt = 0;
        repeat (20) begin
            if (!smp_write && !sr_clk && mux_addr == A_IDLE) cnt++;
            tick;
        end
        chk("R2", "quiet after held request", cnt, 20);
        chk("R1", "enable kept", smp_enable, 1);
    endtask

    initial begin
        int cnt;
        void'($urandom(32'd20250819));
        repeat (3) tick;
        chk("R1", "reset enable", smp_enable, 0);
        chk("R1", "reset write", smp_write, 0);
        chk("R1", "reset load", rsr_load, 0);
        chk("R1", "reset sclk", sr_clk, 0);
        chk("R1", "reset addr", mux_addr, 0);
        chk("R1", "reset done", cap_done, 0);
        rst_n = 1'b1;
        cnt = 0;
        while (!smp_enable) begin cnt++; tick; end
        chk("R1", "settle cycles", cnt, E_SETTLE);
        repeat (10) tick;
        chk("R2", "idle without request", smp_write | sr_clk, 0);
        run_capture(10'h000, 3, 1'b0, 1'b0);
        run_capture(10'h3FF, 0, 1'b1, 1'b0);
        run_capture(10'h2AA, 7, 1'b0, 1'b1);
        for (int i = 0; i < 3; i++) begin
            run_capture(10'($urandom), $urandom_range(1, 40), 1'b0, 1'($urandom_range(0, 1)));
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190_000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule